// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Device

This block is one output stage of a programmable sum-of-products logic device. It takes the OR-sum from the logic array and routes it to a device pin, either through a D flip-flop or directly. It can invert the value on the way out. A product term controls whether the pin driver is on. Two shared terms act on the flip-flop: one clears it at once, and the other sets it at the next clock edge. An active-low power-on input clears it in the same way as the clear term.

The cell also returns one signal to the logic array. In registered mode this is the flip-flop state. In combinational mode it is the driven output while the driver is on, and the value seen on the pin while the driver is off, so the pin can serve as an input. A full output stage uses ten of these cells, and all of them share the clock, clear, preset and power-on signals.

Top module: `pal_out_cell`

## Requirements
- R1: Mode code {cfg_comb,cfg_high}=00 gives registered active-low operation: pin_out is the inverse of the flip-flop. After power-on clear, pin_out reads 1.
- R2: Mode code 01 gives registered active-high operation: pin_out equals the flip-flop.
- R3: Mode code 10 gives combinational active-low operation: pin_out is the inverse of sum_in, with no clock involved.
- R4: Mode code 11 gives combinational active-high operation: pin_out equals sum_in, with no clock involved.
- R5: When cfg_comb=0, fb_out is the flip-flop state. pin_in and oe_term have no effect on it.
- R6: When cfg_comb=1 and oe_term=1, fb_out equals pin_out.
- R7: When cfg_comb=1 and oe_term=0, fb_out equals pin_in.
- R8: pin_oe is 1 exactly while oe_term is 1. When it is 0, the pin is treated as high-impedance.
- R9: If no clear is active and set_term=0, the flip-flop loads sum_in on the rising clock edge.
- R10: If set_term=1 at a rising edge and no clear is active, the flip-flop becomes 1. Before that edge it keeps its old value.
- R11: clr_term=1 clears the flip-flop at once, with no clock edge needed. It overrides set_term.
- R12: por_n=0 clears the flip-flop at once, in the same way as clr_term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| por_n | input | 1 | Active-low power-on clear |
| sum_in | input | 1 | OR-sum from the logic array |
| oe_term | input | 1 | Output-enable product term |
| clr_term | input | 1 | Shared asynchronous clear term |
| set_term | input | 1 | Shared synchronous preset term |
| cfg_comb | input | 1 | 1 = combinational, 0 = registered |
| cfg_high | input | 1 | 1 = active-high, 0 = active-low |
| pin_in | input | 1 | Value present on the external pin |
| pin_out | output | 1 | Data presented to the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback returned to the logic array |

## Verification
Three kinds of result arrive at different times. Combinational outputs, the driver enable, pin feedback and the effect of a clear are due in the same cycle as the input that causes them. Flip-flop loads and the preset take effect only after the next rising edge. The bench changes inputs on falling edges and compares every output twice per cycle: 1 ns after the inputs change, which catches same-cycle results and shows that a preset has not yet acted, and 1 ns after the rising edge, which catches the register update. Its behavioural model advances at the same two points.

// File: rtl/pal_out_cell.sv
module pal_out_cell (
  input  logic clk,
  input  logic por_n,
  input  logic sum_in,
  input  logic oe_term,
  input  logic clr_term,
  input  logic set_term,
  input  logic cfg_comb,
  input  logic cfg_high,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_out
);
  logic q;
  logic sel_d;

  always_ff @(posedge clk or posedge clr_term or negedge por_n) begin
    if (!por_n || clr_term) q <= 1'b0;
    else                    q <= set_term | sum_in;
  end

  assign sel_d   = cfg_comb ? sum_in : q;
  assign pin_out = cfg_high ? sel_d : ~sel_d;
  assign pin_oe  = oe_term;
  assign fb_out  = cfg_comb ? (oe_term ? pin_out : pin_in) : q;
endmodule

// File: rtl/pal_out_cell_chk.sv
module pal_out_cell_chk (
  input logic clk,
  input logic por_n,
  input logic sum_in,
  input logic oe_term,
  input logic clr_term,
  input logic set_term,
  input logic cfg_comb,
  input logic cfg_high,
  input logic pin_in,
  input logic pin_out,
  input logic fb_out
);
  a_r1_r2_reg_polarity: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_comb |-> pin_out == (cfg_high ? fb_out : !fb_out));

  a_r4_comb_follows_sum: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_comb && cfg_high) |-> pin_out == sum_in);

  a_r7_pin_as_input: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_comb && !oe_term) |-> fb_out == pin_in);

  a_r9_load_sum: assert property (@(posedge clk) disable iff (!por_n || clr_term)
    !set_term |=> (cfg_comb || fb_out == $past(sum_in)));

  a_r10_preset_sets: assert property (@(posedge clk) disable iff (!por_n || clr_term)
    set_term |=> (cfg_comb || fb_out));

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!por_n)
    (clr_term && !cfg_comb) |-> !fb_out);
endmodule

bind pal_out_cell pal_out_cell_chk u_chk (
  .clk(clk), .por_n(por_n), .sum_in(sum_in), .oe_term(oe_term),
  .clr_term(clr_term), .set_term(set_term), .cfg_comb(cfg_comb),
  .cfg_high(cfg_high), .pin_in(pin_in), .pin_out(pin_out), .fb_out(fb_out)
);

// File: tb/test_pal_out_cell.sv
`timescale 1ns/100ps
module test_pal_out_cell;
  logic clk = 1'b0;
  logic por_n;
  logic sum_in = 1'b0, oe_term = 1'b0, clr_term = 1'b0, set_term = 1'b0;
  logic cfg_comb = 1'b0, cfg_high = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb_out;

  int total = 0;
  int bad = 0;
  bit mq = 1'b0;

  always #2.5 clk = ~clk;

  pal_out_cell i_pal_out_cell (
    .clk(clk), .por_n(por_n), .sum_in(sum_in), .oe_term(oe_term),
    .clr_term(clr_term), .set_term(set_term), .cfg_comb(cfg_comb),
    .cfg_high(cfg_high), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic check(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at %0t: got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  task automatic compare(bit after_edge);
    bit ed;
    string tp, tf;
    ed = cfg_comb ? sum_in : mq;
    ed = cfg_high ? ed : !ed;
    case ({cfg_comb, cfg_high})
      2'b00: tp = "R1";
      2'b01: tp = "R2";
      2'b10: tp = "R3";
      default: tp = "R4";
    endcase
    if (cfg_comb) tf = oe_term ? "R6" : "R7";
    else if (!por_n) tf = "R12";
    else if (clr_term) tf = "R11";
    else if (set_term) tf = "R10";
    else if (after_edge) tf = "R9";
    else tf = "R5";
    check(tp, pin_out, ed);
    check("R8", pin_oe, oe_term);
    check(tf, fb_out, cfg_comb ? (oe_term ? ed : pin_in) : mq);
  endtask

  task automatic cyc(bit p, bit s, bit oe, bit c, bit st, bit cc, bit ch, bit pi);
    @(negedge clk);
    por_n = p; sum_in = s; oe_term = oe; clr_term = c; set_term = st;
    cfg_comb = cc; cfg_high = ch; pin_in = pi;
    if (!p || c) mq = 1'b0;
    #1 compare(1'b0);
    @(posedge clk);
    if (!por_n || clr_term) mq = 1'b0;
    else mq = set_term | sum_in;
    #1 compare(1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b0;
    // R12 / R1: power-on clear, active-low registered reads 1
    cyc(0, 1, 1, 0, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0, 1);
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    // R9 load, R10 preset, R11 clear overriding preset
    cyc(1, 1, 1, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 1, 0, 1, 1);
    cyc(1, 0, 1, 1, 1, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, 0, 1, 1);
    // R5: pin_in and oe_term ignored in registered mode
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0, 0, 1);
    // R12: power-on clear mid-run
    cyc(0, 1, 1, 0, 1, 0, 1, 0);
    // every mode with varied inputs
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 60; k++) begin
        cyc(($urandom % 23) != 0, $urandom % 2, $urandom % 2,
            ($urandom % 9) == 0, ($urandom % 4) == 0,
            m[1], m[0], $urandom % 2);
      end
    end
    // mode switching on the fly, R3/R4/R6/R7
    for (int k = 0; k < 200; k++) begin
      cyc(1'b1, $urandom % 2, $urandom % 2, ($urandom % 11) == 0,
          ($urandom % 5) == 0, $urandom % 2, $urandom % 2, $urandom % 2);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule